// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Conversion Sequencer

This block is the digital controller of a data-acquisition converter with four simultaneous track/holds. Each track/hold chooses between two inputs, so the converter has eight inputs in two banks. A host writes a 4-bit mode word through the shared parallel bus. The mode word picks the bank, the number of channels converted per sample (one to four), or a power-down state.

A rising edge on the convert strobe starts a sequence. The controller issues one start pulse per channel to an external successive-approximation core, beginning at channel 0, and waits for the core's done pulse. It stores each 12-bit result in a four-entry result store. After the last programmed channel is stored, it pulls the active-low interrupt down.

The host reads results back in channel order only. A read pointer steps forward at the end of each read. It wraps after four reads whatever channel count is programmed, and it returns to channel 0 whenever a new sequence starts.

The bus lines are split into an input half (`bus_in`, the mode-word bits) and a driven half (`bus_out` with its enable `bus_oe`). Pad-level tri-state muxing stays outside the block. All strobes are taken as already synchronous to `clk`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The mode word is `bus_in[3:0]`. Bit 3 set means power-down, and bits 2..0 are then ignored. With bit 3 clear, bit 2 picks the bank (0 or 1) and bits 1..0 give the channel count minus one (0 = one channel, 3 = four channels).
- R2: After reset the mode is bank 0 with one channel, `int_n` is 1, `pwr_down` is 0, `bus_oe` is 0 and no start pulse is issued.
- R3: The mode word present while `cs_n` and `wr_n` are both low takes effect one cycle after whichever of them rises first. It does not take effect while both are still low, and it stays in force until the next write.
- R4: A convert-strobe rising edge seen while idle starts a sequence. The block issues one single-cycle `sar_start` per programmed channel, with `sar_chan` counting 0, 1, 2, 3 in that order and `sar_bank` equal to the programmed bank. Each `sar_done` stores `sar_result` for the current channel.
- R5: Convert-strobe edges that arrive while a sequence is running have no effect.
- R6: `int_n` falls one cycle after the done pulse of the last programmed channel and stays high while a sequence runs. It rises at the start of the first read (`cs_n` and `rd_n` both low) or when a new sequence starts.
- R7: While a read is active, `bus_out` shows the stored result at the read pointer. The pointer advances when the read ends, wraps to channel 0 after channel 3, and returns to channel 0 when a sequence starts.
- R8: While `cs_n` is 1, the block ignores `rd_n` and `wr_n` and holds `bus_oe` at 0. Whenever `bus_oe` is 0, `bus_out` is zero.
- R9: Writing a word with bit 3 clear leaves power-down and applies that word's bank and count.
- R10: While power-down is in force, convert-strobe edges start nothing and `int_n` stays where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| convst | input | 1 | Convert strobe, acts on its rising edge |
| bus_in | input | 4 | Mode-word bits from the shared bus |
| bus_out | output | 12 | Result word driven onto the bus |
| bus_oe | output | 1 | Bus drive enable |
| int_n | output | 1 | Active-low end-of-sequence interrupt |
| pwr_down | output | 1 | Power-down mode in force |
| sar_start | output | 1 | Start pulse to the conversion core |
| sar_chan | output | 2 | Track/hold being converted |
| sar_bank | output | 1 | Bank being converted |
| sar_done | input | 1 | Conversion-complete pulse from the core |
| sar_result | input | 12 | Two's-complement result from the core |

## Verification
Each strobe edge takes effect at the first clock that sees it. A mode change appears one cycle after the write strobe ends. The first `sar_start` appears one cycle after the convert edge, and each later start appears one cycle after the previous done. `int_n` falls one cycle after the final done and rises one cycle after a read begins. `bus_out` and `bus_oe` follow the read strobe within the same cycle. The bench drives inputs just after each rising edge, advances a behavioural model at the rising edge, and compares every output with the model at the falling edge, so each result is sampled in the cycle it is due. Directed checks then confirm start counts, channel order, bank and read-back values per scenario.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_seq_strobe.sv
module adc_seq_strobe #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              convst,
    input  logic [WORD_W-1:0] bus_lo,
    output logic              rd_act,
    output logic              rd_begin,
    output logic              rd_end,
    output logic              wr_end,
    output logic              conv_rise,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              cv;
        logic [WORD_W-1:0] word;
    } strb_t;

    strb_t s_d, s_q;
    logic  wr_act;

    always_comb begin
        rd_act    = !cs_n && !rd_n;
        wr_act    = !cs_n && !wr_n;
        s_d.rd    = rd_act;
        s_d.wr    = wr_act;
        s_d.cv    = convst;
        s_d.word  = wr_act ? bus_lo : s_q.word;
        rd_begin  = rd_act && !s_q.rd;
        rd_end    = !rd_act && s_q.rd;
        wr_end    = !wr_act && s_q.wr;
        conv_rise = convst && !s_q.cv;
        word      = s_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/adc_seq_mode.sv
module adc_seq_mode #(
    parameter int CH_W = 2,
    localparam int WORD_W  = CH_W + 2,
    localparam int BANK_IX = CH_W,
    localparam int PD_IX   = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic [WORD_W-1:0] word,
    output logic              pd,
    output logic              bank,
    output logic [CH_W-1:0]   cnt_m1
);

    typedef struct packed {
        logic            pd;
        logic            bank;
        logic [CH_W-1:0] cnt;
    } mode_t;

    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_end) begin
            if (word[PD_IX]) begin
                m_d.pd = 1'b1;
            end else begin
                m_d.pd   = 1'b0;
                m_d.bank = word[BANK_IX];
                m_d.cnt  = word[CH_W-1:0];
            end
        end
        pd     = m_q.pd;
        bank   = m_q.bank;
        cnt_m1 = m_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_rise,
    input  logic            pd,
    input  logic            bank,
    input  logic [CH_W-1:0] cnt_m1,
    input  logic            rd_begin,
    input  logic            sar_done,
    output logic            sar_start,
    output logic [CH_W-1:0] sar_chan,
    output logic            sar_bank,
    output logic            store_en,
    output logic            ptr_clr,
    output logic            int_n,
    output logic            busy
);

    import adc_seq_pkg::*;

    typedef struct packed {
        seq_state_e      st;
        logic [CH_W-1:0] chan;
        logic [CH_W-1:0] last;
        logic            bank;
        logic            int_n;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        store_en = 1'b0;
        ptr_clr  = 1'b0;
        if (rd_begin) begin
            f_d.int_n = 1'b1;
        end
        case (f_q.st)
            SEQ_IDLE: begin
                if (conv_rise && !pd) begin
                    f_d.st    = SEQ_LAUNCH;
                    f_d.chan  = '0;
                    f_d.last  = cnt_m1;
                    f_d.bank  = bank;
                    f_d.int_n = 1'b1;
                    ptr_clr   = 1'b1;
                end
            end
            SEQ_LAUNCH: begin
                f_d.st = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (sar_done) begin
                    store_en = 1'b1;
                    if (f_q.chan == f_q.last) begin
                        f_d.st    = SEQ_IDLE;
                        f_d.int_n = 1'b0;
                    end else begin
                        f_d.chan = f_q.chan + CH_W'(1);
                        f_d.st   = SEQ_LAUNCH;
                    end
                end
            end
            default: begin
                f_d.st = SEQ_IDLE;
            end
        endcase
        sar_start = (f_q.st == SEQ_LAUNCH);
        sar_chan  = f_q.chan;
        sar_bank  = f_q.bank;
        int_n     = f_q.int_n;
        busy      = (f_q.st != SEQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st    <= SEQ_IDLE;
            f_q.chan  <= '0;
            f_q.last  <= '0;
            f_q.bank  <= 1'b0;
            f_q.int_n <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/adc_seq_rdport.sv
module adc_seq_rdport #(
    parameter int DATA_W = 12,
    parameter int NCH    = 4,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_en,
    input  logic [CH_W-1:0]   store_idx,
    input  logic [DATA_W-1:0] store_data,
    input  logic              ptr_clr,
    input  logic              rd_act,
    input  logic              rd_end,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    typedef struct packed {
        logic [CH_W-1:0] ptr;
    } rp_t;

    rp_t              r_d, r_q;
    logic [DATA_W-1:0] ent_arr [NCH];

    for (genvar e = 0; e < NCH; e++) begin : g_ent
        logic [DATA_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (store_en && (store_idx == CH_W'(e))) begin
                ent_d = store_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_arr[e] = ent_q;
    end

    always_comb begin
        r_d = r_q;
        if (ptr_clr) begin
            r_d.ptr = '0;
        end else if (rd_end) begin
            r_d.ptr = (r_q.ptr == CH_W'(NCH - 1)) ? '0 : r_q.ptr + CH_W'(1);
        end
        bus_oe  = rd_act;
        bus_out = rd_act ? ent_arr[r_q.ptr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int DATA_W = 12,
    parameter int NCH    = 4,
    localparam int CH_W   = $clog2(NCH),
    localparam int WORD_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              convst,
    input  logic [WORD_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              int_n,
    output logic              pwr_down,
    output logic              sar_start,
    output logic [CH_W-1:0]   sar_chan,
    output logic              sar_bank,
    input  logic              sar_done,
    input  logic [DATA_W-1:0] sar_result
);

    logic              rd_act, rd_begin, rd_end, wr_end, conv_rise;
    logic [WORD_W-1:0] word;
    logic              mode_bank;
    logic [CH_W-1:0]   mode_cnt;
    logic              store_en, ptr_clr, seq_busy;

    adc_seq_strobe #(.WORD_W(WORD_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .convst    (convst),
        .bus_lo    (bus_in),
        .rd_act    (rd_act),
        .rd_begin  (rd_begin),
        .rd_end    (rd_end),
        .wr_end    (wr_end),
        .conv_rise (conv_rise),
        .word      (word)
    );

    adc_seq_mode #(.CH_W(CH_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_end (wr_end),
        .word   (word),
        .pd     (pwr_down),
        .bank   (mode_bank),
        .cnt_m1 (mode_cnt)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_rise (conv_rise),
        .pd        (pwr_down),
        .bank      (mode_bank),
        .cnt_m1    (mode_cnt),
        .rd_begin  (rd_begin),
        .sar_done  (sar_done),
        .sar_start (sar_start),
        .sar_chan  (sar_chan),
        .sar_bank  (sar_bank),
        .store_en  (store_en),
        .ptr_clr   (ptr_clr),
        .int_n     (int_n),
        .busy      (seq_busy)
    );

    adc_seq_rdport #(.DATA_W(DATA_W), .NCH(NCH)) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_en   (store_en),
        .store_idx  (sar_chan),
        .store_data (sar_result),
        .ptr_clr    (ptr_clr),
        .rd_act     (rd_act),
        .rd_end     (rd_end),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              int_n,
    input logic              pwr_down,
    input logic              sar_start,
    input logic              sar_done,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              seq_busy
);

    // R4: each start is a single-cycle pulse
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sar_start |=> !sar_start);

    // R6: the interrupt only falls right after a completed conversion
    p_int_fall_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(sar_done));

    // R6: the interrupt only rises on a read or on a new sequence
    p_int_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> ($past(!cs_n && !rd_n) || sar_start));

    // R6: interrupt stays high while a sequence runs
    p_int_high_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> int_n);

    // R8: deselected chip never drives the bus
    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

    // R8: undriven bus data is zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R10: no start while powered down and idle
    p_pd_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !seq_busy) |=> !sar_start);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .int_n     (int_n),
    .pwr_down  (pwr_down),
    .sar_start (sar_start),
    .sar_done  (sar_done),
    .bus_oe    (bus_oe),
    .bus_out   (bus_out),
    .seq_busy  (seq_busy)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

    localparam int DW       = 12;
    localparam int CONV_CYC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, convst = 1'b0;
    logic [3:0]    bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_oe, int_n, pwr_down, sar_start, sar_bank;
    logic [1:0]    sar_chan;
    logic          sar_done = 1'b0;
    logic [DW-1:0] sar_result = '0;

    always #2 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .convst(convst), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .int_n(int_n), .pwr_down(pwr_down), .sar_start(sar_start),
        .sar_chan(sar_chan), .sar_bank(sar_bank), .sar_done(sar_done),
        .sar_result(sar_result)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- conversion core model ----------------
    int sar_cnt = 0, seq_no = 0, n_starts = 0, cur_chan = 0, last_bank = 0;
    int chan_seq[64];
    int exp_res[4];

    always begin
        @(posedge clk);
        #1;
        if (sar_done) sar_done = 1'b0;
        if (sar_cnt > 0) begin
            sar_cnt--;
            if (sar_cnt == 0) begin
                sar_done   = 1'b1;
                sar_result = DW'((seq_no * 53 + last_bank * 1024 + cur_chan * 300 + 7) % 4096);
                exp_res[cur_chan] = int'(sar_result);
            end
        end else if (sar_start) begin
            sar_cnt   = CONV_CYC;
            cur_chan  = int'(sar_chan);
            last_bank = int'(sar_bank);
            if (n_starts < 64) chan_seq[n_starts] = int'(sar_chan);
            n_starts++;
            seq_no++;
        end
    end

    // ---------------- behavioural reference ----------------
    int m_int, m_pd, m_bank, m_cnt, m_state, m_chan, m_last, m_sbank, m_ptr, m_word;
    int m_mem[4];
    bit pr_rd, pr_wr, pr_cv;

    always @(posedge clk) begin
        bit rda, wra, rdb, rde, wre, cvr, clr;
        if (!rst_n) begin
            m_int = 1; m_pd = 0; m_bank = 0; m_cnt = 0; m_state = 0;
            m_chan = 0; m_last = 0; m_sbank = 0; m_ptr = 0; m_word = 0;
            for (int i = 0; i < 4; i++) m_mem[i] = -1;
            pr_rd = 0; pr_wr = 0; pr_cv = 0;
        end else begin
            rda = !cs_n && !rd_n;
            wra = !cs_n && !wr_n;
            rdb = rda && !pr_rd;
            rde = !rda && pr_rd;
            wre = !wra && pr_wr;
            cvr = convst && !pr_cv;
            clr = 0;
            if (rdb) m_int = 1;
            if (m_state == 0) begin
                if (cvr && m_pd == 0) begin
                    m_state = 1; m_chan = 0; m_last = m_cnt; m_sbank = m_bank;
                    m_int = 1; clr = 1;
                end
            end else if (m_state == 1) begin
                m_state = 2;
            end else if (sar_done) begin
                m_mem[m_chan] = int'(sar_result);
                if (m_chan == m_last) begin
                    m_state = 0; m_int = 0;
                end else begin
                    m_chan++; m_state = 1;
                end
            end
            if (clr) m_ptr = 0;
            else if (rde) m_ptr = (m_ptr + 1) % 4;
            if (wre) begin
                if (m_word >= 8) m_pd = 1;
                else begin
                    m_pd = 0; m_bank = (m_word >> 2) & 1; m_cnt = m_word & 3;
                end
            end
            if (wra) m_word = int'(bus_in);
            pr_rd = rda; pr_wr = wra; pr_cv = convst;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6", "int_n", int'(int_n), m_int);
            chk("R1", "pwr_down", int'(pwr_down), m_pd);
            chk("R4", "sar_start", int'(sar_start), int'(m_state == 1));
            if (m_state != 0) begin
                chk("R4", "sar_chan", int'(sar_chan), m_chan);
                chk("R4", "sar_bank", int'(sar_bank), m_sbank);
            end
            chk("R8", "bus_oe", int'(bus_oe), int'(!cs_n && !rd_n));
            if (bus_oe && m_mem[m_ptr] >= 0)
                chk("R7", "bus_out", int'(bus_out), m_mem[m_ptr]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_word(input logic [3:0] w);
        cs_n = 0; wr_n = 0; bus_in = w; step(); step();
        wr_n = 1; step();
        cs_n = 1; step();
    endtask

    task automatic read_word(output int v);
        cs_n = 0; rd_n = 0;
        @(negedge clk);
        v = int'(bus_out);
        step();
        rd_n = 1; step();
        cs_n = 1; step();
    endtask

    task automatic pulse_conv();
        convst = 1; step();
        convst = 0; step();
    endtask

    task automatic wait_int();
        for (int i = 0; i < 2000 && int_n; i++) step();
    endtask

    task automatic chk_order(string req, int base, int n, int bank);
        chk(req, "start count", n_starts - base, n);
        for (int i = 0; i < n; i++) chk(req, "channel order", chan_seq[base + i], i);
        chk(req, "bank", last_bank, bank);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        int v, base;
        repeat (3) step();
        rst_n = 1; step();
        // R2 reset state
        chk("R2", "int_n after reset", int'(int_n), 1);
        chk("R2", "pwr_down after reset", int'(pwr_down), 0);
        chk("R2", "bus_oe after reset", int'(bus_oe), 0);
        chk("R2", "sar_start after reset", int'(sar_start), 0);

        // R2/R4 default single channel on bank 0
        base = n_starts;
        pulse_conv(); wait_int();
        chk("R6", "int_n low at end", int'(int_n), 0);
        chk_order("R4", base, 1, 0);
        read_word(v);
        chk("R7", "single read", v, exp_res[0]);
        chk("R6", "int_n after read", int'(int_n), 1);

        // R1/R5 bank 1 four channels, extra strobe mid-sequence
        write_word(4'b0111);
        base = n_starts;
        pulse_conv(); repeat (10) step();
        pulse_conv(); repeat (40) step();
        pulse_conv(); wait_int();
        chk_order("R5", base, 4, 1);
        for (int i = 0; i < 4; i++) begin
            read_word(v);
            chk("R7", "ordered read", v, exp_res[i]);
        end
        read_word(v);
        chk("R7", "wrap to channel 0", v, exp_res[0]);

        // R8 write and read with chip deselected are ignored
        cs_n = 1; wr_n = 0; bus_in = 4'b1000; step(); step();
        wr_n = 1; rd_n = 0; step();
        chk("R8", "bus_oe deselected", int'(bus_oe), 0);
        rd_n = 1; step(); step();
        chk("R8", "pwr_down unchanged", int'(pwr_down), 0);
        base = n_starts;
        pulse_conv(); wait_int();
        chk_order("R8", base, 4, 1);

        // R7 pointer returns to channel 0 on a new sequence
        write_word(4'b0001);
        pulse_conv(); wait_int();
        read_word(v);
        chk("R7", "first of two", v, exp_res[0]);
        base = n_starts;
        pulse_conv(); wait_int();
        chk_order("R4", base, 2, 0);
        read_word(v);
        chk("R7", "pointer reset by start", v, exp_res[0]);

        // R3/R10 power-down held off until strobe ends, then blocks starts
        cs_n = 0; wr_n = 0; bus_in = 4'b1101; step(); step();
        chk("R3", "no effect while strobes low", int'(pwr_down), 0);
        wr_n = 1; step();
        chk("R3", "power-down after strobe", int'(pwr_down), 1);
        cs_n = 1; step();
        base = n_starts;
        pulse_conv(); repeat (100) step();
        chk("R10", "no start in power-down", n_starts - base, 0);
        chk("R10", "int_n unchanged", int'(int_n), 1);

        // R9 wake with three channels on bank 0
        write_word(4'b0010);
        chk("R9", "power-down cleared", int'(pwr_down), 0);
        base = n_starts;
        pulse_conv(); wait_int();
        chk_order("R9", base, 3, 0);

        // R3 chip select rising first latches the word
        cs_n = 0; wr_n = 0; bus_in = 4'b0100; step(); step();
        cs_n = 1; step();
        wr_n = 1; step();
        base = n_starts;
        pulse_conv(); wait_int();
        chk_order("R3", base, 1, 1);
        read_word(v);
        chk("R3", "result after cs-first write", v, exp_res[0]);

        repeat (5) step();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule